// File: doc/BRIEF.md
# Front-Panel Switch and Lamp Controller

This block holds the switch logic of a minicomputer-style operator panel whose switches are all momentary push buttons. A serial scan path reads the raw button levels and drives the button LEDs. Each raw level is debounced over several scans, and a press then does one of three things. For a latching switch it flips a stored on/off state, and that switch's LED shows the state. For a momentary key it produces a single one-cycle pulse. For the selector key it steps a six-position indicator selector, shown on six one-hot LEDs.

The two lamp rows are driven in parallel. The 12-lamp indicator row shows whichever of six 12-bit data sources the selector picks. The 15-lamp address row shows a 3-bit field and a 12-bit memory address. Both rows are re-registered on every clock, so a register that changes quickly appears partly lit instead of flickering. Lamp 0 of each row carries the most significant bit, which keeps groups of three lamps aligned for octal reading. All data sources are plain input ports. There is no stream traffic at the edge of this block, so it has no valid/ready handshake and no back-pressure: every port is a plain level or pulse.

Top module: `panel_switch_ctrl`

## Requirements
- R1: After reset all latched switch states are 0, `sel_onehot` is 6'b000001 (position 0) and `mom_pulse` is 0.
- R2: Each debounced press of a latching button (scan slot k, with k < NUM_LATCH) inverts `sw_state[k]` once. Releasing the button and holding it have no effect.
- R3: A debounced press of momentary button m (scan slot NUM_LATCH+m) produces exactly one clock cycle of `mom_pulse[m]` and changes no latched state.
- R4: Each debounced press of the selector button (scan slot NUM_LATCH+NUM_MOM) moves the one-hot `sel_onehot` from bit p to bit p+1, and from bit 5 back to bit 0. Exactly one bit is always set.
- R5: One clock after any input change, `ind_lamps[i]` equals bit 11-i of the selected source. Source s occupies `ind_src[12*s+11 : 12*s]`.
- R6: One clock after any input change, `addr_lamps[i]` equals bit 14-i of the 15-bit word {field_in, addr_in}. Lamps 0 to 2 therefore hold the field, most significant bit first.
- R7: The scan frame repeats every 2*FB+2 clocks, where FB = max(NUM_LATCH+NUM_MOM+1, NUM_LATCH+6).
  - `spi_cs_n` is low for the first 2*FB clocks of the frame and high for the last 2.
  - While `spi_cs_n` is low there are FB bit slots of 2 clocks each, with `spi_sclk` low and then high.
  - `spi_miso` is sampled while `spi_sclk` is high, and slot k reads button k.
- R8: In slot k, `spi_mosi` carries `sw_state[k]` for k < NUM_LATCH, carries `sel_onehot[k-NUM_LATCH]` for the next 6 slots, and carries 0 in any remaining slot.
- R9: A new raw button level takes effect only after DEB_SCANS consecutive scans show that level. A shorter bounce has no effect.
- R10: Presses of different buttons that become valid in the same scan all take effect in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| spi_sclk | output | 1 | Scan serial clock |
| spi_cs_n | output | 1 | Scan frame select, active low |
| spi_mosi | output | 1 | LED bit for the current slot |
| spi_miso | input | 1 | Button bit for the current slot |
| sw_state | output | NUM_LATCH | Latched switch states |
| mom_pulse | output | NUM_MOM | One-cycle momentary key pulses |
| sel_onehot | output | 6 | Indicator selector position, one-hot |
| ind_src | input | 72 | Six packed 12-bit indicator sources |
| field_in | input | 3 | Extended field |
| addr_in | input | 12 | Memory address |
| ind_lamps | output | 12 | Indicator lamp row, lamp 0 is the MSB |
| addr_lamps | output | 15 | Address lamp row, lamp 0 is the MSB |

## Verification
A selector step and a switch toggle can fall in the same clock when both buttons are debounced by the same scan. The bench provokes this by raising a latching button, a momentary button and the selector button together. It then judges that the switch flipped, the selector advanced by exactly one position and exactly one momentary pulse appeared. The bench also observes the serial LED frame, so it can confirm that the LED shifted out for each of these effects agrees with the parallel outputs.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int SEL_POS = 6;
  localparam int IND_W   = 12;
  localparam int ADDR_W  = 12;
  localparam int FIELD_W = 3;
  localparam int ALAMP_W = FIELD_W + ADDR_W;
  typedef logic [SEL_POS-1:0] sel_oh_t;
endpackage

// File: rtl/fp_scan.sv
module fp_scan #(
  parameter int FB = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FB-1:0] led_word,
  input  logic          spi_miso,
  output logic          spi_sclk,
  output logic          spi_cs_n,
  output logic          spi_mosi,
  output logic [FB-1:0] frame_word,
  output logic          frame_valid
);
  localparam int FRAME_CYC = 2 * FB + 2;
  localparam int CW = $clog2(FRAME_CYC);
  localparam int SW = (FB > 1) ? $clog2(FB) : 1;

  logic [CW-1:0] cnt;
  logic [FB-1:0] shreg;
  logic          active;
  logic [SW-1:0] slot;

  assign active   = (cnt < CW'(2 * FB));
  assign slot     = SW'(cnt >> 1);
  assign spi_cs_n = !active;
  assign spi_sclk = active && cnt[0];
  assign spi_mosi = active && led_word[slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      shreg       <= '0;
      frame_word  <= '0;
      frame_valid <= 1'b0;
    end else begin
      cnt         <= (cnt == CW'(FRAME_CYC - 1)) ? '0 : cnt + 1'b1;
      frame_valid <= (cnt == CW'(2 * FB));
      if (active && cnt[0]) shreg[slot] <= spi_miso;
      if (cnt == CW'(2 * FB)) frame_word <= shreg;
    end
  end

  // R7: a finished frame is handed on just after select rises
  a_r7_frame_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> frame_valid);
endmodule

// File: rtl/fp_debounce.sv
module fp_debounce #(
  parameter int W   = 15,
  parameter int DEB = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_valid,
  input  logic [W-1:0] sample,
  output logic [W-1:0] level,
  output logic [W-1:0] press
);
  localparam int CW = $clog2(DEB + 1);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [CW-1:0] run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        level[i] <= 1'b0;
        press[i] <= 1'b0;
        run      <= '0;
      end else begin
        press[i] <= 1'b0;
        if (sample_valid) begin
          if (sample[i] == level[i]) begin
            run <= '0;
          end else if (run == CW'(DEB - 1)) begin
            level[i] <= sample[i];
            press[i] <= sample[i];
            run      <= '0;
          end else begin
            run <= run + 1'b1;
          end
        end
      end
    end

    // R9: the debounced level moves only on a scan result
    a_r9_level_on_scan: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid |=> $stable(level[i]));
    // R3: a press event lasts a single clock
    a_r3_press_single: assert property (@(posedge clk) disable iff (!rst_n)
      press[i] |=> !press[i]);
  end
endmodule

// File: rtl/fp_switch_bank.sv
module fp_switch_bank
  import fp_pkg::*;
#(
  parameter int NUM_LATCH = 6,
  parameter int NUM_MOM   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LATCH-1:0] press_lat,
  input  logic [NUM_MOM-1:0]   press_mom,
  input  logic                 press_sel,
  output logic [NUM_LATCH-1:0] sw_state,
  output logic [NUM_MOM-1:0]   mom_pulse,
  output sel_oh_t              sel_onehot
);
  assign mom_pulse = press_mom;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_state   <= '0;
      sel_onehot <= sel_oh_t'(1);
    end else begin
      sw_state <= sw_state ^ press_lat;
      if (press_sel) sel_onehot <= {sel_onehot[SEL_POS-2:0], sel_onehot[SEL_POS-1]};
    end
  end

  // R4: exactly one selector position is active
  a_r4_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_onehot) == 1);
  // R4: the last position steps back to the first
  a_r4_sel_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    press_sel && sel_onehot[SEL_POS-1] |=> sel_onehot[0]);

  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_sw
    // R2: a press flips the switch, nothing else moves it
    a_r2_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      press_lat[i] |=> sw_state[i] != $past(sw_state[i]));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !press_lat[i] |=> $stable(sw_state[i]));
  end
endmodule

// File: rtl/fp_lamps.sv
module fp_lamps
  import fp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SEL_POS*IND_W-1:0] ind_src,
  input  sel_oh_t                  sel_onehot,
  input  logic [FIELD_W-1:0]       field_in,
  input  logic [ADDR_W-1:0]        addr_in,
  output logic [IND_W-1:0]         ind_lamps,
  output logic [ALAMP_W-1:0]       addr_lamps
);
  logic [IND_W-1:0]   pick;
  logic [ALAMP_W-1:0] aword;

  always_comb begin
    pick = '0;
    for (int s = 0; s < SEL_POS; s++)
      if (sel_onehot[s]) pick = pick | ind_src[s*IND_W +: IND_W];
    aword = {field_in, addr_in};
  end

  // Lamp rows follow the data every clock; lamp 0 carries the MSB.
  always_ff @(posedge clk) begin
    for (int i = 0; i < IND_W; i++)   ind_lamps[i]  <= pick[IND_W-1-i];
    for (int i = 0; i < ALAMP_W; i++) addr_lamps[i] <= aword[ALAMP_W-1-i];
  end

  // R6: lamp 0 of the address row shows the top field bit
  a_r6_field_msb: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> addr_lamps[0] == $past(field_in[FIELD_W-1]));
  // R6: last address lamp shows the address LSB
  a_r6_addr_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> addr_lamps[ALAMP_W-1] == $past(addr_in[0]));
endmodule

// File: rtl/panel_switch_ctrl.sv
module panel_switch_ctrl
  import fp_pkg::*;
#(
  parameter int NUM_LATCH = 6,
  parameter int NUM_MOM   = 8,
  parameter int DEB_SCANS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic                     spi_sclk,
  output logic                     spi_cs_n,
  output logic                     spi_mosi,
  input  logic                     spi_miso,
  output logic [NUM_LATCH-1:0]     sw_state,
  output logic [NUM_MOM-1:0]       mom_pulse,
  output logic [SEL_POS-1:0]       sel_onehot,
  input  logic [SEL_POS*IND_W-1:0] ind_src,
  input  logic [FIELD_W-1:0]       field_in,
  input  logic [ADDR_W-1:0]        addr_in,
  output logic [IND_W-1:0]         ind_lamps,
  output logic [ALAMP_W-1:0]       addr_lamps
);
  localparam int NB   = NUM_LATCH + NUM_MOM + 1;
  localparam int NLED = NUM_LATCH + SEL_POS;
  localparam int FB   = (NB > NLED) ? NB : NLED;
  localparam int SEL_SLOT = NUM_LATCH + NUM_MOM;

  logic [FB-1:0] led_word, frame_word, level, press;
  logic          frame_valid;

  always_comb begin
    led_word = '0;
    led_word[NUM_LATCH-1:0] = sw_state;
    led_word[NUM_LATCH +: SEL_POS] = sel_onehot;
  end

  fp_scan #(.FB(FB)) u_scan (
    .clk(clk), .rst_n(rst_n), .led_word(led_word), .spi_miso(spi_miso),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .frame_word(frame_word), .frame_valid(frame_valid));

  fp_debounce #(.W(FB), .DEB(DEB_SCANS)) u_deb (
    .clk(clk), .rst_n(rst_n), .sample_valid(frame_valid), .sample(frame_word),
    .level(level), .press(press));

  fp_switch_bank #(.NUM_LATCH(NUM_LATCH), .NUM_MOM(NUM_MOM)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .press_lat(press[NUM_LATCH-1:0]),
    .press_mom(press[NUM_LATCH +: NUM_MOM]),
    .press_sel(press[SEL_SLOT]),
    .sw_state(sw_state), .mom_pulse(mom_pulse), .sel_onehot(sel_onehot));

  fp_lamps u_lamps (
    .clk(clk), .rst_n(rst_n), .ind_src(ind_src), .sel_onehot(sel_onehot),
    .field_in(field_in), .addr_in(addr_in),
    .ind_lamps(ind_lamps), .addr_lamps(addr_lamps));

  // R10: switch flips and selector steps issued by one scan land together
  a_r10_same_scan: assert property (@(posedge clk) disable iff (!rst_n)
    press[0] && press[SEL_SLOT] |=> sw_state[0] != $past(sw_state[0])
                                     && sel_onehot != $past(sel_onehot));
endmodule

// File: tb/test_panel_switch_ctrl.sv
module test_panel_switch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 6, NM = 8, DEB = 3;
  localparam int FB = NL + NM + 1;
  localparam int FRAME = 2 * FB + 2;
  localparam int SEL_SLOT = NL + NM;

  logic clk = 0, rst_n = 0;
  logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic [NL-1:0] sw_state;
  logic [NM-1:0] mom_pulse;
  logic [5:0] sel_onehot;
  logic [71:0] ind_src;
  logic [2:0] field_in = 0;
  logic [11:0] addr_in = 0;
  logic [11:0] ind_lamps;
  logic [14:0] addr_lamps;

  int checks = 0, fails = 0, cyc = 0, idx = 0, sclk_rises = 0, frame_rises = 0, mom_cnt = 0;
  logic [FB-1:0] btn_model = '0, led_cap = '0, led_frame = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_switch_ctrl #(.NUM_LATCH(NL), .NUM_MOM(NM), .DEB_SCANS(DEB)) i_panel_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .sw_state(sw_state),
    .mom_pulse(mom_pulse), .sel_onehot(sel_onehot), .ind_src(ind_src),
    .field_in(field_in), .addr_in(addr_in), .ind_lamps(ind_lamps),
    .addr_lamps(addr_lamps));

  // Serial button/LED device model
  assign spi_miso = (!spi_cs_n && idx < FB) ? btn_model[idx] : 1'b0;
  always @(negedge spi_cs_n) begin idx = 0; sclk_rises = 0; end
  always @(negedge spi_sclk) idx = idx + 1;
  always @(posedge spi_sclk) begin
    sclk_rises = sclk_rises + 1;
    if (idx < FB) led_cap[idx] = spi_mosi;
  end
  always @(posedge spi_cs_n) begin led_frame = led_cap; frame_rises = sclk_rises; end
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n) mom_cnt = mom_cnt + $countones(mom_pulse);
  end

  function automatic logic [11:0] src_val(int s);
    return 12'(s * 12'h2D3 + 12'h105);
  endfunction
  function automatic logic [11:0] rev12(logic [11:0] v);
    logic [11:0] r;
    for (int i = 0; i < 12; i++) r[i] = v[11-i];
    return r;
  endfunction
  function automatic logic [14:0] rev15(logic [14:0] v);
    logic [14:0] r;
    for (int i = 0; i < 15; i++) r[i] = v[14-i];
    return r;
  endfunction
  function automatic logic [FB-1:0] exp_leds(logic [NL-1:0] sw, logic [5:0] sel);
    logic [FB-1:0] w = '0;
    w[NL-1:0] = sw;
    w[NL +: 6] = sel;
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frames(int n);
    repeat (n * FRAME) @(negedge clk);
  endtask

  task automatic tap(logic [FB-1:0] keys);
    btn_model = keys;
    frames(DEB + 2);
    btn_model = '0;
    frames(DEB + 2);
  endtask

  task automatic t_reset;
    check("R1 sw_state", 32'(sw_state), 0);
    check("R1 sel_onehot", 32'(sel_onehot), 1);
    check("R1 mom_pulse", 32'(mom_pulse), 0);
    frames(2);
    check("R8 reset LED frame", 32'(led_frame), 32'(exp_leds('0, 6'b1)));
  endtask

  task automatic t_frame;
    int t0;
    @(negedge spi_cs_n); t0 = cyc;
    @(negedge spi_cs_n);
    check("R7 frame period", 32'(cyc - t0), FRAME);
    @(posedge spi_cs_n); #1;
    check("R7 sclk slots per frame", 32'(frame_rises), FB);
  endtask

  task automatic t_latch;
    tap(FB'(1) << 2);
    check("R2 switch 2 on", 32'(sw_state), 32'h4);
    frames(2);
    check("R8 LED shows switch 2", 32'(led_frame), 32'(exp_leds(6'h4, 6'b1)));
    tap(FB'(1) << 2);
    check("R2 switch 2 off again", 32'(sw_state), 0);
  endtask

  task automatic t_mom;
    int c0 = mom_cnt;
    tap(FB'(1) << (NL + 3));
    check("R3 one momentary pulse", 32'(mom_cnt - c0), 1);
    check("R3 no latched change", 32'(sw_state), 0);
  endtask

  task automatic t_select;
    for (int p = 1; p <= 6; p++) begin
      tap(FB'(1) << SEL_SLOT);
      check("R4 selector step", 32'(sel_onehot), 32'(1 << (p % 6)));
      check("R5 indicator lamps", 32'(ind_lamps), 32'(rev12(src_val(p % 6))));
    end
  endtask

  task automatic t_ind_follow;
    ind_src[11:0] = 12'hFFF;
    @(negedge clk);
    check("R5 indicator follows within one clock", 32'(ind_lamps), 32'hFFF);
    ind_src[11:0] = src_val(0);
    @(negedge clk);
  endtask

  task automatic t_addr;
    field_in = 3'o4; addr_in = 12'o1234;
    @(negedge clk);
    check("R6 address lamps a", 32'(addr_lamps), 32'(rev15({3'o4, 12'o1234})));
    field_in = 3'o1; addr_in = 12'o7001;
    @(negedge clk);
    check("R6 address lamps b", 32'(addr_lamps), 32'(rev15({3'o1, 12'o7001})));
  endtask

  task automatic t_bounce;
    btn_model = FB'(1);
    frames(DEB - 1);
    btn_model = '0;
    frames(DEB + 2);
    check("R9 short bounce ignored", 32'(sw_state), 0);
  endtask

  task automatic t_same;
    int c0 = mom_cnt;
    tap((FB'(1) << 1) | (FB'(1) << SEL_SLOT) | (FB'(1) << NL));
    check("R10 switch 1 flipped", 32'(sw_state), 32'h2);
    check("R10 selector one step", 32'(sel_onehot), 32'h2);
    check("R10 one momentary pulse", 32'(mom_cnt - c0), 1);
    frames(2);
    check("R10 LED frame", 32'(led_frame), 32'(exp_leds(6'h2, 6'h2)));
  endtask

  initial begin
    for (int s = 0; s < 6; s++) ind_src[s*12 +: 12] = src_val(s);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_frame;
    t_latch;
    t_mom;
    t_select;
    t_ind_follow;
    t_addr;
    t_bounce;
    t_same;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule